// File: doc/BRIEF.md
# Scoreboard In-Order Issue Unit

This block sits between instruction decode and a pair of fixed-latency functional units in a small machine with eight architectural registers. Every instruction carries an operation code, one destination register and two source registers. Decoded instructions enter a four-entry buffer through a valid/ready handshake. Each cycle the oldest buffered instruction is checked against a per-register scoreboard. It issues only when no hazard exists, so issue is strictly in order.

The scoreboard holds two things for each register: a count of reads by issued instructions that have not yet started executing, and a flag for a result that has not yet been written back. An instruction is held back for any of three reasons. The first is that one of its sources waits on a result (read after write). The second is that its destination still owes a read to an older instruction (write after read). The third is that its destination already has a result in flight (write after write). While the head is held, the buffer stops draining. Once the buffer is full, the fetch side sees ready drop.

An issued instruction executes in the next cycle. Short operations return their result two cycles after issue, and multiplies three cycles after issue, each on its own writeback port. A result that returns in a cycle clears its register's flag in time for that same cycle's hazard check.

Top module: `scoreboard_issue`

## Requirements
- R1: While reset is held, inReady is 1 and issueValid, aluWbValid and mulWbValid are 0.
- R2: When the buffer is not empty and no hazard holds, issueValid is 1 and the issue ports carry the oldest buffered instruction. Instructions issue in arrival order, at most one per cycle. An instruction accepted in cycle k can issue in cycle k+1 at the earliest. A stalled head stays at the head unchanged.
- R3: The head does not issue while either of its source registers has an unreturned result.
- R4: The head does not issue while its destination register has a pending read. A read counts as pending from the issue cycle of its instruction through the following cycle, in which that instruction executes.
- R5: The head does not issue while its destination register already has an unreturned result, so two results never return to the same register in one cycle.
- R6: An instruction issued in cycle N with inOp = 2'b10 (multiply) appears on mulWbValid/mulWbReg in cycle N+3. Any other inOp (2'b00 add, 2'b01 subtract, 2'b11 treated like add) appears on aluWbValid/aluWbReg in cycle N+2. The writeback register is the instruction's destination.
- R7: The buffer holds 4 instructions. inReady is 0 exactly when 4 are held. An instruction is accepted in a cycle where inValid and inReady are both 1.
- R8: A result returning in cycle C clears its register's flag for the hazard check of cycle C, so a dependent head may issue in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Decoded instruction offered |
| inReady | output | 1 | Buffer can accept an instruction |
| inOp | input | 2 | Operation: 00 add, 01 subtract, 10 multiply, 11 short |
| inDst | input | 3 | Destination register |
| inSrcA | input | 3 | First source register |
| inSrcB | input | 3 | Second source register |
| issueValid | output | 1 | Head instruction issues this cycle |
| issueOp | output | 2 | Operation of the issued instruction |
| issueDst | output | 3 | Destination of the issued instruction |
| issueSrcA | output | 3 | First source of the issued instruction |
| issueSrcB | output | 3 | Second source of the issued instruction |
| aluWbValid | output | 1 | Short-latency result returns |
| aluWbReg | output | 3 | Register written by the short result |
| mulWbValid | output | 1 | Multiply result returns |
| mulWbReg | output | 3 | Register written by the multiply result |

## Verification
The assertions assume that reset is applied before the first instruction. They also assume that the instruction fields hold known values whenever inValid is high, since the hazard indices come straight from those fields. The bench holds reset for several cycles and builds every offered instruction from a packed code with all fields defined. Its directed sequences place a dependent instruction right behind a short or a multiply producer, so each hazard kind, the same-cycle release and a full buffer all occur. A long random run over all eight registers and all four operation codes then mixes these cases.

// File: rtl/issue_pkg.sv
package issue_pkg;
  localparam int NumRegs = 8;
  localparam int RegW = $clog2(NumRegs);

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MUL = 2'b10,
    OP_SHORT = 2'b11
  } op_e;

  typedef struct packed {
    op_e            op;
    logic [RegW-1:0] dst;
    logic [RegW-1:0] srcA;
    logic [RegW-1:0] srcB;
  } instr_t;

  typedef struct packed {
    logic            valid;
    logic [RegW-1:0] dst;
  } wb_t;

  // strobes from control to datapath
  typedef struct packed {
    logic issue;
  } strobe_t;
endpackage

// File: rtl/issue_datapath.sv
module issue_datapath
  import issue_pkg::*;
#(
  parameter int BufDepth = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  instr_t  inInstr,
  output logic    inReady,
  input  strobe_t strb,
  output logic    headValid,
  output instr_t  headInstr,
  output logic    execValid,
  output instr_t  execInstr,
  output wb_t     aluWb,
  output wb_t     mulWb
);
  localparam int PtrW = (BufDepth > 1) ? $clog2(BufDepth) : 1;
  localparam int CntW = $clog2(BufDepth + 1);
  localparam int MulStages = 2;

  instr_t slots [BufDepth];
  logic [PtrW-1:0] rdPtr, wrPtr;
  logic [CntW-1:0] count;
  logic push, pop;

  function automatic logic [PtrW-1:0] nextPtr(input logic [PtrW-1:0] p);
    return (p == PtrW'(BufDepth - 1)) ? '0 : p + 1'b1;
  endfunction

  assign inReady   = (count != CntW'(BufDepth));
  assign push      = inValid && inReady;
  assign pop       = strb.issue;
  assign headValid = (count != '0);
  assign headInstr = slots[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop) rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) slots[wrPtr] <= inInstr;
  end

  // execute stage and short-latency writeback stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      execValid <= 1'b0;
      execInstr <= '0;
      aluWb     <= '0;
    end else begin
      execValid <= strb.issue;
      if (strb.issue) execInstr <= headInstr;
      aluWb.valid <= execValid && (execInstr.op != OP_MUL);
      aluWb.dst   <= execInstr.dst;
    end
  end

  // multiply pipe
  wb_t mulPipe [MulStages];
  for (genvar s = 0; s < MulStages; s++) begin : g_mul
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) mulPipe[0] <= '0;
        else begin
          mulPipe[0].valid <= execValid && (execInstr.op == OP_MUL);
          mulPipe[0].dst   <= execInstr.dst;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) mulPipe[s] <= '0;
        else mulPipe[s] <= mulPipe[s-1];
      end
    end
  end
  assign mulWb = mulPipe[MulStages-1];

  assert_head_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (headValid && !strb.issue) |=> (headValid && headInstr == $past(headInstr)));
  assert_fill_count_R7: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop) |=> (count == $past(count) + 1'b1));
  assert_alu_latency_R6: assert property (@(posedge clk) disable iff (!rstN)
    aluWb.valid |-> ($past(strb.issue, 2) && $past(headInstr.op, 2) != OP_MUL));
  assert_mul_latency_R6: assert property (@(posedge clk) disable iff (!rstN)
    mulWb.valid |-> ($past(strb.issue, 3) && $past(headInstr.op, 3) == OP_MUL));
endmodule

// File: rtl/issue_control.sv
module issue_control
  import issue_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    headValid,
  input  instr_t  headInstr,
  input  logic    execValid,
  input  instr_t  execInstr,
  input  wb_t     aluWb,
  input  wb_t     mulWb,
  output strobe_t strb
);
  localparam int MaxReads = 4;
  localparam int CntW = $clog2(MaxReads + 1);

  logic            writePend [NumRegs];
  logic            effPend   [NumRegs];
  logic [CntW-1:0] readCnt   [NumRegs];
  logic rawHaz, warHaz, wawHaz;

  for (genvar r = 0; r < NumRegs; r++) begin : g_reg
    localparam logic [RegW-1:0] Idx = RegW'(r);
    logic            wbClear, setW;
    logic [CntW-1:0] incr, decr;

    assign wbClear = (aluWb.valid && aluWb.dst == Idx) || (mulWb.valid && mulWb.dst == Idx);
    assign effPend[r] = writePend[r] && !wbClear;
    assign setW = strb.issue && (headInstr.dst == Idx);
    assign incr = strb.issue ? (CntW'(headInstr.srcA == Idx) + CntW'(headInstr.srcB == Idx)) : '0;
    assign decr = execValid ? (CntW'(execInstr.srcA == Idx) + CntW'(execInstr.srcB == Idx)) : '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        writePend[r] <= 1'b0;
        readCnt[r]   <= '0;
      end else begin
        writePend[r] <= effPend[r] || setW;
        readCnt[r]   <= readCnt[r] + incr - decr;
      end
    end
  end

  always_comb begin
    rawHaz = effPend[headInstr.srcA] || effPend[headInstr.srcB];
    wawHaz = effPend[headInstr.dst];
    warHaz = (readCnt[headInstr.dst] != '0);
    strb.issue = headValid && !(rawHaz || warHaz || wawHaz);
  end

  assert_dst_marked_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue |=> writePend[$past(headInstr.dst)]);
  assert_wb_distinct_R5: assert property (@(posedge clk) disable iff (!rstN)
    (aluWb.valid && mulWb.valid) |-> (aluWb.dst != mulWb.dst));
  assert_read_owed_R4: assert property (@(posedge clk) disable iff (!rstN)
    execValid |-> (readCnt[execInstr.srcA] != '0 && readCnt[execInstr.srcB] != '0));
endmodule

// File: rtl/scoreboard_issue.sv
module scoreboard_issue
  import issue_pkg::*;
#(
  parameter int BufDepth = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output logic       inReady,
  input  logic [1:0] inOp,
  input  logic [2:0] inDst,
  input  logic [2:0] inSrcA,
  input  logic [2:0] inSrcB,
  output logic       issueValid,
  output logic [1:0] issueOp,
  output logic [2:0] issueDst,
  output logic [2:0] issueSrcA,
  output logic [2:0] issueSrcB,
  output logic       aluWbValid,
  output logic [2:0] aluWbReg,
  output logic       mulWbValid,
  output logic [2:0] mulWbReg
);
  instr_t  inInstr, headInstr, execInstr;
  strobe_t strb;
  logic    headValid, execValid;
  wb_t     aluWb, mulWb;

  assign inInstr.op   = op_e'(inOp);
  assign inInstr.dst  = inDst;
  assign inInstr.srcA = inSrcA;
  assign inInstr.srcB = inSrcB;

  issue_datapath #(.BufDepth(BufDepth)) datapath_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inInstr(inInstr), .inReady(inReady),
    .strb(strb), .headValid(headValid), .headInstr(headInstr),
    .execValid(execValid), .execInstr(execInstr), .aluWb(aluWb), .mulWb(mulWb)
  );

  issue_control control_i (
    .clk(clk), .rstN(rstN), .headValid(headValid), .headInstr(headInstr),
    .execValid(execValid), .execInstr(execInstr), .aluWb(aluWb), .mulWb(mulWb),
    .strb(strb)
  );

  assign issueValid = strb.issue;
  assign issueOp    = headInstr.op;
  assign issueDst   = headInstr.dst;
  assign issueSrcA  = headInstr.srcA;
  assign issueSrcB  = headInstr.srcB;
  assign aluWbValid = aluWb.valid;
  assign aluWbReg   = aluWb.dst;
  assign mulWbValid = mulWb.valid;
  assign mulWbReg   = mulWb.dst;
endmodule

// File: tb/scoreboard_issue_tb_top.sv
module scoreboard_issue_tb_top;
  localparam int ClkPeriod = 10;
  localparam int Depth = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid, inReady;
  logic [1:0] inOp;
  logic [2:0] inDst, inSrcA, inSrcB;
  logic issueValid, aluWbValid, mulWbValid;
  logic [1:0] issueOp;
  logic [2:0] issueDst, issueSrcA, issueSrcB, aluWbReg, mulWbReg;

  int checks = 0;
  int errors = 0;
  int stim[$];
  bit randGate = 0;

  // reference model state
  int qOp[$], qD[$], qA[$], qB[$];
  int mRead[8];
  bit mPend[8];
  bit exV, alV, m1V, m2V;
  int exOp, exD, exA, exB, alR, m1R, m2R;
  bit sawFull, sawRaw, sawWar, sawWaw, sawSame;

  always #(ClkPeriod/2) clk = ~clk;

  scoreboard_issue dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inOp(inOp), .inDst(inDst), .inSrcA(inSrcA), .inSrcB(inSrcB),
    .issueValid(issueValid), .issueOp(issueOp), .issueDst(issueDst),
    .issueSrcA(issueSrcA), .issueSrcB(issueSrcB),
    .aluWbValid(aluWbValid), .aluWbReg(aluWbReg),
    .mulWbValid(mulWbValid), .mulWbReg(mulWbReg)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int enc(input int op, input int d, input int a, input int b);
    return (op << 9) | (d << 6) | (a << 3) | b;
  endfunction

  task automatic step();
    bit eReady, eIssue, hv, raw, war, waw, touch;
    int hOp, hD, hA, hB;
    bit eff[8];
    string tag;
    @(negedge clk);
    eReady = qOp.size() < Depth;
    for (int r = 0; r < 8; r++)
      eff[r] = mPend[r] && !(alV && alR == r) && !(m2V && m2R == r);
    hv = qOp.size() > 0;
    hOp = 0; hD = 0; hA = 0; hB = 0;
    if (hv) begin hOp = qOp[0]; hD = qD[0]; hA = qA[0]; hB = qB[0]; end
    raw = hv && (eff[hA] || eff[hB]);
    war = hv && mRead[hD] != 0;
    waw = hv && eff[hD];
    touch = hv && ((mPend[hA] && !eff[hA]) || (mPend[hB] && !eff[hB]) || (mPend[hD] && !eff[hD]));
    eIssue = hv && !raw && !war && !waw;
    tag = raw ? "R3" : war ? "R4" : waw ? "R5" : touch ? "R8" : "R2";
    if (!eReady) sawFull = 1;
    if (raw) sawRaw = 1;
    if (war) sawWar = 1;
    if (waw) sawWaw = 1;
    if (eIssue && touch) sawSame = 1;

    chk("R7", "inReady", inReady, eReady);
    chk(tag, "issueValid", issueValid, eIssue);
    if (eIssue) begin
      chk("R2", "issueOp", issueOp, hOp);
      chk("R2", "issueDst", issueDst, hD);
      chk("R2", "issueSrcA", issueSrcA, hA);
      chk("R2", "issueSrcB", issueSrcB, hB);
    end
    chk("R6", "aluWbValid", aluWbValid, alV);
    if (alV) chk("R6", "aluWbReg", aluWbReg, alR);
    chk("R6", "mulWbValid", mulWbValid, m2V);
    if (m2V) chk("R6", "mulWbReg", mulWbReg, m2R);

    // drive next inputs
    if (stim.size() > 0 && (!randGate || $urandom_range(0, 9) < 7)) begin
      inValid = 1'b1;
      inOp   = 2'((stim[0] >> 9) & 3);
      inDst  = 3'((stim[0] >> 6) & 7);
      inSrcA = 3'((stim[0] >> 3) & 7);
      inSrcB = 3'(stim[0] & 7);
    end else begin
      inValid = 1'b0;
    end

    // advance model by one clock
    if (alV) mPend[alR] = 0;
    if (m2V) mPend[m2R] = 0;
    if (exV) begin mRead[exA]--; mRead[exB]--; end
    if (eIssue) begin mRead[hA]++; mRead[hB]++; mPend[hD] = 1; end
    m2V = m1V; m2R = m1R;
    m1V = exV && exOp == 2; m1R = exD;
    alV = exV && exOp != 2; alR = exD;
    exV = eIssue; exOp = hOp; exD = hD; exA = hA; exB = hB;
    if (eIssue) begin
      void'(qOp.pop_front()); void'(qD.pop_front());
      void'(qA.pop_front()); void'(qB.pop_front());
    end
    if (inValid && eReady) begin
      qOp.push_back(int'(inOp)); qD.push_back(int'(inDst));
      qA.push_back(int'(inSrcA)); qB.push_back(int'(inSrcB));
      void'(stim.pop_front());
    end
  endtask

  task automatic drain();
    while (stim.size() > 0) step();
    repeat (10) step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    inValid = 1'b0; inOp = '0; inDst = '0; inSrcA = '0; inSrcB = '0;
    for (int r = 0; r < 8; r++) begin mRead[r] = 0; mPend[r] = 0; end
    exV = 0; alV = 0; m1V = 0; m2V = 0;
    exOp = 0; exD = 0; exA = 0; exB = 0; alR = 0; m1R = 0; m2R = 0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk("R1", "inReady in reset", inReady, 1);
    chk("R1", "issueValid in reset", issueValid, 0);
    chk("R1", "aluWbValid in reset", aluWbValid, 0);
    chk("R1", "mulWbValid in reset", mulWbValid, 0);
    rstN = 1'b1;

    // R3/R8: short producer then consumer
    stim.push_back(enc(0, 3, 1, 2)); stim.push_back(enc(0, 4, 3, 0)); drain();
    // R3/R6: multiply producer then subtract consumer
    stim.push_back(enc(2, 5, 1, 2)); stim.push_back(enc(1, 6, 5, 5)); drain();
    // R4: destination is a source of the previous instruction
    stim.push_back(enc(0, 1, 2, 3)); stim.push_back(enc(0, 2, 4, 5)); drain();
    // R5: same destination, multiply then add
    stim.push_back(enc(2, 7, 0, 1)); stim.push_back(enc(0, 7, 2, 3)); drain();
    // R6: code 11 behaves as short
    stim.push_back(enc(3, 2, 0, 0)); stim.push_back(enc(0, 3, 2, 2)); drain();
    // R7: dependent multiply chain fills the buffer
    for (int i = 0; i < 10; i++) stim.push_back(enc(2, 1, 1, 1));
    drain();

    // random mix
    randGate = 1;
    for (int i = 0; i < 2500; i++)
      stim.push_back(enc($urandom_range(0, 3), $urandom_range(0, 7),
                         $urandom_range(0, 7), $urandom_range(0, 7)));
    drain();

    chk("R7", "buffer reached full", sawFull, 1);
    chk("R3", "read-after-write stall seen", sawRaw, 1);
    chk("R4", "write-after-read stall seen", sawWar, 1);
    chk("R5", "write-after-write stall seen", sawWaw, 1);
    chk("R8", "issue in release cycle seen", sawSame, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule